// File: doc/BRIEF.md
# Queue Interrupt Status Controller

This block turns the status flags of 32 hardware queues into a single interrupt request for a host processor. Every queue presents four level flags: empty, nearly empty, nearly full and full. A three-bit source code per queue picks one of these flags, or its inverse. When the picked signal goes from low to high, the queue's bit in a sticky pending word is set. The interrupt line is a registered OR over the pending bits whose enable bits are set.

The host reaches the block over a simple word-addressed register bus. Writes take effect at the next clock edge, and reads are combinational from the address. There are four source-select words holding eight queues each, one enable word and one pending word. The host clears pending bits by writing ones to them. Clearing an enable bit also discards that queue's pending request, so turning a queue off leaves no stale request behind.

Top module: `qirq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0.
- R2: Queue n's source code lives in select word n/8 (addresses 0 to 3) at bits [(n mod 8)*4 +: 3]. A write stores only those three bits of each 4-bit slot, and bit 3 of every slot always reads 0.
- R3: The source code picks the watched signal from the queue's flag nibble `q_cond[4n +: 4]`, whose bit 0 is empty, bit 1 nearly empty, bit 2 nearly full and bit 3 full. Codes 0 to 3 select bits 0 to 3 directly, and codes 4 to 7 select the inverse of bits 0 to 3.
- R4: A pending bit is set at the clock edge where its watched signal is first seen high after being low. A signal that simply stays high does not set the bit again after it is cleared.
- R5: A write to the pending word (address 5) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When a queue's pending bit is set and cleared in the same cycle, it ends up set.
- R7: The enable word (address 4) is written as a whole 32-bit word and reads back what was written.
- R8: Any write to the enable word that changes a bit from 1 to 0 also clears that queue's pending bit. A pending bit whose enable was already 0 is kept.
- R9: `irq_o` is high in the cycle after the one in which (pending AND enable) is nonzero, and low in the cycle after it becomes zero.
- R10: Addresses 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| q_cond | input | 128 | Four status flags per queue, queue n at bits [4n+3:4n] |
| irq_o | output | 1 | Registered interrupt request to the host |

## Verification
The assertions assume that the queue flags are synchronous to `clk` and stable around its rising edge. They also assume that the bus carries at most one write per cycle, with a valid address whenever `bus_wr` is high. The bench meets these assumptions by changing every input one time unit after a rising edge and by keeping the write strobe to a single cycle per access. The stimulus also keeps all flags low through reset, so that no edge is recorded at start-up.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
    localparam int COND_W = 4;   // flags per queue
    localparam int SEL_W  = 3;   // source code width
    localparam int SLOT_W = 4;   // select slot width, top bit reserved

    typedef enum logic [SEL_W-1:0] {
        SRC_EMPTY      = 3'd0,
        SRC_NEAR_EMPTY = 3'd1,
        SRC_NEAR_FULL  = 3'd2,
        SRC_FULL       = 3'd3,
        SRC_NOT_EMPTY  = 3'd4,
        SRC_NOT_NEMPTY = 3'd5,
        SRC_NOT_NFULL  = 3'd6,
        SRC_NOT_FULL   = 3'd7
    } src_code_e;
endpackage

// File: rtl/qirq_cond_mux.sv
module qirq_cond_mux
    import qirq_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit
);
    // R3: low two code bits pick the flag, top code bit inverts it
    always_comb begin
        hit = cond[sel[1:0]] ^ sel[2];
    end
endmodule

// File: rtl/qirq_edge_det.sv
module qirq_edge_det #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
        rise   = level & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R4: a reported rise is never repeated in the next cycle
    p_no_double_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
    import qirq_pkg::*;
#(
    parameter int NUM_Q  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_Q*COND_W-1:0]  q_cond,
    output logic                     irq_o
);
    localparam int QPW     = DATA_W / SLOT_W;       // queues per select word
    localparam int NUM_SEL = NUM_Q / QPW;           // select words
    localparam int SEL_AW  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1;
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(NUM_SEL);
    localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(NUM_SEL + 1);

    typedef struct packed {
        logic [NUM_Q-1:0][SEL_W-1:0] sel;
        logic [NUM_Q-1:0]            en;
        logic [NUM_Q-1:0]            pend;
        logic                        irq;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_Q-1:0]  watched;
    logic [NUM_Q-1:0]  rise;
    logic [NUM_Q-1:0]  clr;
    logic [DATA_W-1:0] sel_word [NUM_SEL];

    // per-queue source selection
    for (genvar q = 0; q < NUM_Q; q++) begin : g_mux
        qirq_cond_mux u_mux (
            .cond (q_cond[q*COND_W +: COND_W]),
            .sel  (st_q.sel[q]),
            .hit  (watched[q])
        );
    end

    qirq_edge_det #(.W(NUM_Q)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (watched),
        .rise  (rise)
    );

    // select words as seen by the host, reserved bits zero
    for (genvar r = 0; r < NUM_SEL; r++) begin : g_selw
        always_comb begin
            sel_word[r] = '0;
            for (int j = 0; j < QPW; j++) begin
                sel_word[r][j*SLOT_W +: SEL_W] = st_q.sel[r*QPW + j];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (bus_wr) begin
            for (int i = 0; i < NUM_Q; i++) begin
                if (bus_addr == ADDR_W'(i / QPW)) begin
                    st_d.sel[i] = bus_wdata[(i % QPW)*SLOT_W +: SEL_W];
                end
            end
            if (bus_addr == A_EN) begin
                st_d.en = bus_wdata[NUM_Q-1:0];
                clr     = st_q.en & ~bus_wdata[NUM_Q-1:0];
            end
            if (bus_addr == A_ST) begin
                clr = bus_wdata[NUM_Q-1:0];
            end
        end
        // a new edge beats any clear in the same cycle
        st_d.pend = (st_q.pend & ~clr) | rise;
        st_d.irq  = |(st_q.pend & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(NUM_SEL)) bus_rdata = sel_word[bus_addr[SEL_AW-1:0]];
        else if (bus_addr == A_EN)       bus_rdata = DATA_W'(st_q.en);
        else if (bus_addr == A_ST)       bus_rdata = DATA_W'(st_q.pend);
    end

    assign irq_o = st_q.irq;

    // R2: reserved slot bits never read as 1
    p_sel_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < ADDR_W'(NUM_SEL)) |-> ((bus_rdata & {QPW{4'b1000}}) == '0));

    // R4: a rise always leaves its pending bit set
    p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((st_q.pend & $past(rise)) == $past(rise)));

    // R5: bits written as 1 with no competing rise are cleared
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ST) |=>
        ((st_q.pend & $past(bus_wdata[NUM_Q-1:0] & ~rise)) == '0));

    // R4/R5: without a rise or a write the pending word holds
    p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && rise == '0) |=> (st_q.pend == $past(st_q.pend)));

    // R8: switching a queue off drops its request
    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN) |=>
        ((st_q.pend & $past(st_q.en & ~bus_wdata[NUM_Q-1:0] & ~rise)) == '0));

    // R9: interrupt follows enabled pending one cycle later
    p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(st_q.pend & st_q.en))));

    // R10: unused addresses read zero
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > A_ST) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_qirq_ctrl.sv
module tb_qirq_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] q_cond = '0;
    logic         irq_o;

    int checks = 0;
    int errors = 0;
    int sel_m [32];
    logic [31:0] v;

    always #10 clk = ~clk;   // 50 MHz

    qirq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .q_cond(q_cond), .irq_o(irq_o)
    );

    // {queue[4:0], code[2:0], before[3:0], after[3:0], expect}
    localparam logic [16:0] VEC [11] = '{
        {5'd3,  3'd0, 4'b0000, 4'b0001, 1'b1},
        {5'd9,  3'd1, 4'b0000, 4'b0010, 1'b1},
        {5'd17, 3'd2, 4'b0000, 4'b0100, 1'b1},
        {5'd31, 3'd3, 4'b0000, 4'b1000, 1'b1},
        {5'd0,  3'd4, 4'b0001, 4'b0000, 1'b1},
        {5'd12, 3'd5, 4'b0010, 4'b0000, 1'b1},
        {5'd20, 3'd6, 4'b0100, 4'b0000, 1'b1},
        {5'd27, 3'd7, 4'b1000, 4'b0000, 1'b1},
        {5'd5,  3'd0, 4'b0001, 4'b0000, 1'b0},
        {5'd14, 3'd3, 4'b0000, 4'b0111, 1'b0},
        {5'd22, 3'd4, 4'b0000, 4'b0001, 1'b0}
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_code(input int q, input int code);
        logic [31:0] w;
        sel_m[q] = code;
        w = '0;
        for (int j = 0; j < 8; j++) w[j*4 +: 3] = 3'(sel_m[(q/8)*8 + j]);
        wr(3'(q/8), w);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) sel_m[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 / R10: reset values and unused addresses
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v); chk("R1", v, 32'h0);
        end
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2: slot packing and reserved bits
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk("R2", v, 32'h7777_7777);
        wr(3'd2, 32'h1234_5678); rd(3'd2, v); chk("R2", v, 32'h1234_5670);
        rd(3'd0, v); chk("R2 other word", v, 32'h0);
        wr(3'd1, 32'h0); wr(3'd2, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);

        // R7: whole-word enable
        wr(3'd4, 32'hA5A5_0F0F); rd(3'd4, v); chk("R7", v, 32'hA5A5_0F0F);
        // R10: writes to unused addresses ignored
        wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'h1234_5678);
        rd(3'd6, v); chk("R10", v, 32'h0);
        rd(3'd4, v); chk("R10 en kept", v, 32'hA5A5_0F0F);
        rd(3'd0, v); chk("R10 sel kept", v, 32'h0);
        wr(3'd4, 32'h0); wr(3'd5, 32'hFFFF_FFFF);

        // R4 / R9: queue 4 watching empty
        q_cond[16] = 1'b1; tick();
        rd(3'd5, v); chk("R4 set", v, 32'h10);
        chk("R9 masked", {31'b0, irq_o}, 32'h0);
        wr(3'd4, 32'h10);
        chk("R9 lag", {31'b0, irq_o}, 32'h0);
        tick();
        chk("R9 high", {31'b0, irq_o}, 32'h1);
        // R5: zeros leave bits alone, ones clear them
        wr(3'd5, 32'hFFFF_FFEF); rd(3'd5, v); chk("R5 zero kept", v, 32'h10);
        wr(3'd5, 32'h10); rd(3'd5, v); chk("R5 cleared", v, 32'h0);
        chk("R9 still high", {31'b0, irq_o}, 32'h1);
        tick();
        chk("R9 low", {31'b0, irq_o}, 32'h0);
        // R4: level held does not re-set
        tick(); tick(); tick();
        rd(3'd5, v); chk("R4 level", v, 32'h0);
        // R6: set and clear together
        q_cond[16] = 1'b0; tick();
        q_cond[16] = 1'b1; wr(3'd5, 32'h10);
        rd(3'd5, v); chk("R6", v, 32'h10);
        // R8: disabling clears pending
        wr(3'd4, 32'h0); rd(3'd5, v); chk("R8 cleared", v, 32'h0);
        tick();
        chk("R8 irq", {31'b0, irq_o}, 32'h0);
        q_cond[16] = 1'b0; tick();
        q_cond[16] = 1'b1; tick();
        wr(3'd4, 32'h0); rd(3'd5, v); chk("R8 not enabled kept", v, 32'h10);
        q_cond[16] = 1'b0; tick(); wr(3'd5, 32'hFFFF_FFFF);

        // R3: source code table
        foreach (VEC[k]) begin
            int q;
            q = int'(VEC[k][16:12]);
            q_cond[q*4 +: 4] = VEC[k][8:5];
            set_code(q, int'(VEC[k][11:9]));
            tick(); tick();
            wr(3'd5, 32'hFFFF_FFFF);
            q_cond[q*4 +: 4] = VEC[k][4:1];
            tick();
            rd(3'd5, v);
            chk("R3", v, VEC[k][0] ? (32'h1 << q) : 32'h0);
            q_cond[q*4 +: 4] = 4'b0000;
            tick();
        end
        chk("R9 none enabled", {31'b0, irq_o}, 32'h0);

        finish_run();
    end
endmodule